// File: doc/BRIEF.md
# Asynchronous Character Transmitter

This block serialises one character at a time onto an asynchronous line. An external bit clock arrives as a one-cycle enable pulse, `bit_tick`. Each character goes out as a low start bit, the data bits least significant first, an optional parity bit, and a high stop period. Plain control pins set the character size, the parity, the stop length and a divide-by-16 option. The host hands over characters through a one-entry buffer with a valid/ready handshake.

When no character is being shifted, a selectable output state controls the line:
- released (output enable low),
- driven low,
- driven high,
- loopback.

In loopback the pin stays high and the frame is steered to a separate loopback output. A break request holds the line low once the character in flight has finished. Three flags report status: `in_ready` doubles as buffer-empty, `eot` means disabled and drained, and `underrun` is sticky.

Back-pressure rules on the buffer:
- `in_ready` is high exactly when the buffer is empty.
- A character is taken on a clock edge where `in_valid` and `in_ready` are both high.
- While `in_ready` is low, `in_data` is ignored, and the host must hold `in_valid` and `in_data` until the transfer happens.

Top module: `serial_char_tx`

## Requirements
- R1: A frame is a low start bit, then the data bits LSB first, then the parity bit if enabled, then a high stop period. Every start, data and parity bit lasts 1 `bit_tick` with `div16`=0 and 16 ticks with `div16`=1.
- R2: `char_code` 0, 1, 2, 3 selects 8, 7, 6, 5 data bits. Buffer bits above the chosen size are neither sent nor counted in the parity.
- R3: With `par_en`=1 a parity bit is sent. `par_even`=1 makes it the XOR of the data bits (even parity). `par_even`=0 makes it the inverse (odd parity). With `par_en`=0 no parity bit is sent.
- R4: The stop period is set by `stop_code` and `div16`:
  - with `div16`=1: code 3 gives 32 ticks, code 2 gives 24 ticks, codes 1 and 0 give 16 ticks;
  - with `div16`=0: code 3 gives 2 ticks, codes 2, 1 and 0 give 1 tick.
  - Code 0 (synchronous mode) is not provided and acts as one stop bit.
- R5: A frame starts on a `bit_tick` edge where the transmitter is enabled, the buffer holds a character and `brk`=0. This includes the tick that ends the previous stop period, so characters go out back to back. Configuration is captured when the frame starts.
- R6: When no frame is in progress and break is not in force, `line_mode` sets the line:
  - 0: `ser_oe`=0, `ser_out`=1;
  - 1: `ser_oe`=1, `ser_out`=0;
  - 2 or 3: `ser_oe`=1, `ser_out`=1.
  - `lb_out` is 1 in all of these cases.
- R7: With `brk`=1 and `tx_en`=1, no new frame starts. Once the current frame ends, the line is driven low (`ser_oe`=1, `ser_out`=0) whatever `line_mode` is.
- R8: The buffer holds one character. `in_ready`=1 exactly while it is empty, and it is filled on an edge with `in_valid`=1 and `in_ready`=1.
- R9: In loopback (`line_mode`=3), during a frame `ser_out` stays 1 with `ser_oe`=1 and `lb_out` carries the frame. In other modes the frame appears on `ser_out` with `ser_oe`=1.
- R10: `underrun` is set when a stop period ends while the buffer is empty and `tx_en`=1. It stays set until `status_rd` is pulsed, and a set on the same edge wins over the clear.
- R11: `eot` is 1 exactly when `tx_en`=0 and no frame is in progress. A frame in progress always completes, even after `tx_en` falls.
- R12: After reset the buffer is empty, `underrun` is 0 and no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-clock enable |
| tx_en | input | 1 | Transmitter enable |
| char_code | input | 2 | Character size code (0=8 ... 3=5 bits) |
| stop_code | input | 2 | Stop length code |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | 1=even parity, 0=odd parity |
| div16 | input | 1 | 1=16 ticks per bit, 0=1 tick per bit |
| line_mode | input | 2 | Line state while idle (0 released, 1 low, 2 high, 3 loopback) |
| brk | input | 1 | Break request |
| status_rd | input | 1 | Status read pulse, clears underrun |
| in_valid | input | 1 | Host character valid |
| in_data | input | 8 | Host character |
| in_ready | output | 1 | Buffer empty / ready to accept |
| ser_out | output | 1 | Serial line level |
| ser_oe | output | 1 | Serial line output enable |
| lb_out | output | 1 | Loopback copy of the frame |
| eot | output | 1 | End of transmission |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench keeps a per-tick queue of expected line levels and compares the line on every clock. Its stimulus targets these corner cases:
- **Back-to-back characters.** A design that idles for a tick between characters would show a stray high level where a start bit belongs.
- **Short characters with all-ones data.** Sending parity-covered characters this way exposes upper buffer bits leaking into the frame or the parity.
- **1.5 stop bits in both clock modes.** A design that got this wrong would stretch or truncate the 24-tick stop, or add a tick in /1 mode.
- **Break raised mid-character and underrun raced against a status read.** These catch a character launched during break, a frame cut short, or a lost underrun.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int TICK_W = 5;  // holds up to 32 ticks (2 stop bits at /16)

  typedef enum logic [1:0] {
    LN_HIZ  = 2'd0,
    LN_LOW  = 2'd1,
    LN_HIGH = 2'd2,
    LN_LOOP = 2'd3
  } line_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_BITS = 2'd1,
    PH_STOP = 2'd2
  } phase_e;
endpackage

// File: rtl/stx_holdbuf.sv
module stx_holdbuf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else begin
      if (take) full <= 1'b0;
      if (in_valid && !full) begin
        full <= 1'b1;
        q    <= in_data;
      end
    end
  end

  assign in_ready = !full;

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);  // R8
endmodule

// File: rtl/stx_framer.sv
module stx_framer #(
  parameter int W    = 8,
  parameter int NB_W = $clog2(W + 3)
) (
  input  logic [W-1:0]    data,
  input  logic [1:0]      char_code,
  input  logic            par_en,
  input  logic            par_even,
  output logic [W+1:0]    frame,
  output logic [NB_W-1:0] nbits
);
  localparam int FRM_W = W + 2;

  int          n_data;
  logic [W-1:0] masked;
  logic         pbit;

  always_comb begin
    n_data = W - int'(char_code);
    for (int i = 0; i < W; i++) masked[i] = (i < n_data) ? data[i] : 1'b0;
    pbit  = par_even ? (^masked) : ~(^masked);
    nbits = NB_W'(1 + n_data + (par_en ? 1 : 0));
  end

  assign frame[0] = 1'b0;  // start bit
  for (genvar k = 1; k < FRM_W; k++) begin : g_slot
    always_comb begin
      if (k - 1 < n_data)       frame[k] = masked[k-1];
      else if (k - 1 == n_data) frame[k] = pbit;
      else                      frame[k] = 1'b1;
    end
  end
endmodule

// File: rtl/stx_engine.sv
module stx_engine
  import stx_pkg::*;
#(
  parameter int W    = 8,
  parameter int NB_W = $clog2(W + 3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_tick,
  input  logic            tx_en,
  input  logic            brk,
  input  logic            buf_full,
  input  logic            div16,
  input  logic [1:0]      stop_code,
  input  logic            status_rd,
  input  logic [W+1:0]    frame,
  input  logic [NB_W-1:0] nbits,
  output logic            take,
  output logic            active,
  output logic            level,
  output logic            underrun
);
  phase_e              phase;
  logic [W+1:0]        sh;
  logic [NB_W-1:0]     nb;
  logic [TICK_W-1:0]   cnt, bit_last, stop_last;
  logic [TICK_W-1:0]   bit_len_m1, stop_len_m1;
  logic                stop_done;

  always_comb begin
    bit_len_m1 = div16 ? TICK_W'(15) : TICK_W'(0);
    if (div16)
      case (stop_code)
        2'd2:    stop_len_m1 = TICK_W'(23);
        2'd3:    stop_len_m1 = TICK_W'(31);
        default: stop_len_m1 = TICK_W'(15);
      endcase
    else
      stop_len_m1 = (stop_code == 2'd3) ? TICK_W'(1) : TICK_W'(0);
  end

  assign stop_done = bit_tick && (phase == PH_STOP) && (cnt == '0);
  assign take      = bit_tick && tx_en && !brk && buf_full &&
                     ((phase == PH_IDLE) || stop_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      sh        <= '1;
      nb        <= '0;
      cnt       <= '0;
      bit_last  <= '0;
      stop_last <= '0;
    end else if (take) begin
      phase     <= PH_BITS;
      sh        <= frame;
      nb        <= nbits;
      cnt       <= bit_len_m1;
      bit_last  <= bit_len_m1;
      stop_last <= stop_len_m1;
    end else if (stop_done) begin
      phase <= PH_IDLE;
    end else if (bit_tick && phase != PH_IDLE) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (phase == PH_BITS) begin
        if (nb == NB_W'(1)) begin
          phase <= PH_STOP;
          cnt   <= stop_last;
        end else begin
          sh  <= {1'b1, sh[W+1:1]};
          nb  <= nb - 1'b1;
          cnt <= bit_last;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             underrun <= 1'b0;
    else if (stop_done && !buf_full && tx_en) underrun <= 1'b1;
    else if (status_rd)                     underrun <= 1'b0;
  end

  assign active = (phase != PH_IDLE);
  assign level  = (phase == PH_BITS) ? sh[0] : 1'b1;

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (active && !level));  // R1
  AST_UNDERRUN_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !$past(underrun)) |-> $past(phase == PH_STOP));  // R10
endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              tx_en,
  input  logic [1:0]        char_code,
  input  logic [1:0]        stop_code,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              div16,
  input  logic [1:0]        line_mode,
  input  logic              brk,
  input  logic              status_rd,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              lb_out,
  output logic              eot,
  output logic              underrun
);
  localparam int NB_W = $clog2(DATA_W + 3);

  logic              buf_full, take, active, level;
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W+1:0] frame;
  logic [NB_W-1:0]   nbits;
  line_mode_e        mode;

  assign mode = line_mode_e'(line_mode);

  stx_holdbuf #(.W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(take), .full(buf_full), .q(buf_q)
  );

  stx_framer #(.W(DATA_W), .NB_W(NB_W)) u_frm (
    .data(buf_q), .char_code(char_code), .par_en(par_en),
    .par_even(par_even), .frame(frame), .nbits(nbits)
  );

  stx_engine #(.W(DATA_W), .NB_W(NB_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en), .brk(brk),
    .buf_full(buf_full), .div16(div16), .stop_code(stop_code),
    .status_rd(status_rd), .frame(frame), .nbits(nbits), .take(take),
    .active(active), .level(level), .underrun(underrun)
  );

  always_comb begin
    lb_out  = 1'b1;
    ser_oe  = 1'b1;
    ser_out = 1'b1;
    if (active) begin
      if (mode == LN_LOOP) lb_out  = level;
      else                 ser_out = level;
    end else if (brk && tx_en) begin
      ser_out = 1'b0;
    end else begin
      case (mode)
        LN_HIZ:  ser_oe  = 1'b0;
        LN_LOW:  ser_out = 1'b0;
        default: ser_out = 1'b1;
      endcase
    end
  end

  assign eot = !tx_en && !active;

  AST_TAKE_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (buf_full && !in_ready));  // R8
  AST_NO_LAUNCH_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !($rose(active)));  // R7
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !active) |=> !active);  // R11
endmodule

// File: tb/serial_char_tx_test.sv
module serial_char_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, tx_en = 1'b0, par_en = 1'b0, par_even = 1'b0;
  logic div16 = 1'b0, brk = 1'b0, status_rd = 1'b0, in_valid = 1'b0;
  logic [1:0] char_code = 2'd0, stop_code = 2'd1, line_mode = 2'd0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, ser_out, ser_oe, lb_out, eot, underrun;

  int n_cmp = 0, n_bad = 0, tick_every = 1;
  bit chk_on = 1'b0;

  always #5 clk = ~clk;

  serial_char_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .char_code(char_code), .stop_code(stop_code), .par_en(par_en),
    .par_even(par_even), .div16(div16), .line_mode(line_mode), .brk(brk),
    .status_rd(status_rd), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .ser_out(ser_out), .ser_oe(ser_oe),
    .lb_out(lb_out), .eot(eot), .underrun(underrun)
  );

  // bit clock pulses every tick_every system clocks
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1 >= tick_every) ? 0 : tcnt + 1;
    bit_tick <= (tcnt == 0);
  end

  // ---------------- behavioural reference model ----------------
  bit       lvl_q[$];
  bit       m_full, m_under;
  bit [7:0] m_data;

  task automatic push_lvl(input bit v, input int len);
    for (int i = 0; i < len; i++) lvl_q.push_back(v);
  endtask

  always @(posedge clk) begin
    bit was_full, fin, launch, par;
    int n, per, stop_len;
    if (!rst_n) begin
      lvl_q.delete(); m_full = 0; m_under = 0; m_data = 0;
    end else begin
      was_full = m_full; fin = 0; launch = 0;
      if (bit_tick) begin
        if (lvl_q.size() > 0) begin
          void'(lvl_q.pop_front());
          if (lvl_q.size() == 0) fin = 1;
        end
        if (lvl_q.size() == 0 && was_full && tx_en && !brk) launch = 1;
      end
      if (fin && !was_full && tx_en) m_under = 1;
      else if (status_rd)            m_under = 0;
      if (launch) begin
        n   = 8 - char_code;
        per = div16 ? 16 : 1;
        par = 0;
        push_lvl(0, per);
        for (int i = 0; i < n; i++) begin
          push_lvl(m_data[i], per);
          par = par ^ m_data[i];
        end
        if (par_en) push_lvl(par_even ? par : ~par, per);
        if (div16) stop_len = (stop_code == 3) ? 32 : (stop_code == 2) ? 24 : 16;
        else       stop_len = (stop_code == 3) ? 2 : 1;
        push_lvl(1, stop_len);
        m_full = 0;
      end
      if (in_valid && !was_full) begin
        m_full = 1; m_data = in_data;
      end
    end
  end

  task automatic cmp1(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always begin
    bit e_out, e_oe, e_lb;
    @(negedge clk); #3;
    if (chk_on) begin
      e_lb = 1; e_oe = 1; e_out = 1;
      if (lvl_q.size() > 0) begin
        if (line_mode == 3) e_lb = lvl_q[0]; else e_out = lvl_q[0];
      end else if (brk && tx_en) e_out = 0;
      else if (line_mode == 0) e_oe = 0;
      else if (line_mode == 1) e_out = 0;
      if (lvl_q.size() > 0) begin
        cmp1("R1 R2 R3 R4 R5 R9 ser_out", ser_out, e_out);
        cmp1("R9 lb_out", lb_out, e_lb);
      end else begin
        cmp1("R6 R7 ser_out", ser_out, e_out);
        cmp1("R6 lb_out", lb_out, e_lb);
      end
      cmp1("R6 R9 ser_oe", ser_oe, e_oe);
      cmp1("R8 in_ready", in_ready, !m_full);
      cmp1("R10 underrun", underrun, m_under);
      cmp1("R11 eot", eot, !tx_en && lvl_q.size() == 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [7:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0; in_data = 8'h5A;  // junk while not valid
  endtask

  task automatic drain();
    while (lvl_q.size() != 0 || m_full) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_status();
    status_rd = 1; @(negedge clk); status_rd = 0;
  endtask

  task automatic cfg(input int cc, input int sc, input bit pe, input bit pv,
                     input bit d16, input int tk);
    char_code = 2'(cc); stop_code = 2'(sc); par_en = pe; par_even = pv;
    div16 = d16; tick_every = tk;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_on = 1;  // R12 reset state compared here
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 R5 R8: 8N1 back to back, /1, tick every clock
    tx_en = 1; line_mode = 2;
    cfg(0, 1, 0, 0, 0, 1);
    send(8'hA5); send(8'h3C); send(8'h81);
    drain();
    rd_status();  // R10 clear
    // R2 R3 R4: 7 bits even parity 2 stop, upper bit ignored
    cfg(1, 3, 1, 1, 0, 2);
    send(8'hFF); send(8'h7F); send(8'h80);
    drain();
    // R3 R4: 5 bits odd parity, stop code 0
    cfg(3, 0, 1, 0, 0, 3);
    send(8'hE3); send(8'h1C);
    drain();
    // R1 R4: /16, 6 bits even parity, 1.5 stop
    cfg(2, 2, 1, 1, 1, 1);
    send(8'hC9); send(8'h36);
    drain();
    // R4: /16 two stop and one stop, odd parity
    cfg(0, 3, 1, 0, 1, 2);
    send(8'h96);
    drain();
    cfg(0, 1, 0, 0, 1, 1);
    send(8'h01);
    drain();
    // R4: 1.5 stop in /1 acts as one
    cfg(0, 2, 0, 0, 0, 1);
    send(8'h55); send(8'hAA);
    drain();
    // R10: status read racing the underrun set
    send(8'h0F);
    while (lvl_q.size() != 1) @(negedge clk);
    status_rd = 1; @(negedge clk); status_rd = 0;
    drain();
    rd_status();
    // R7: break mid-frame, queued char held, released later
    cfg(0, 1, 1, 1, 0, 2);
    send(8'h42);
    repeat (4) @(negedge clk);
    brk = 1;
    send(8'h24);
    repeat (60) @(negedge clk);
    line_mode = 0; repeat (5) @(negedge clk);
    brk = 0;
    drain();
    // R9: loopback
    line_mode = 3;
    send(8'hB7); send(8'h6D);
    drain();
    // R6 R11: idle states, disable mid-frame drains
    for (int m = 0; m < 4; m++) begin
      line_mode = 2'(m); repeat (4) @(negedge clk);
    end
    line_mode = 1;
    send(8'hC3);
    repeat (5) @(negedge clk);
    tx_en = 0;
    drain();
    send(8'h11);  // held in buffer while disabled
    repeat (30) @(negedge clk);
    tx_en = 1;
    drain();
    rd_status();
    repeat (5) @(negedge clk);
    chk_on = 0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule